// File: doc/BRIEF.md
# Low-Power Mode Entry Sequencer

This block decides how a small processor subsystem powers down when the core executes a wait-for-interrupt, and how it comes back. A wait strobe, or a return from an exception handler while the return-to-sleep control bit is set, is an entry request. A deep-select bit chooses the mode. With deep-select low, the block takes a light sleep, where only the core clock is held off. With deep-select high, it takes a stop, where the core domain clock, the PLL and both oscillators are turned off. The regulator low-power and flash power-down controls are also driven, based on two configuration bits that are captured at entry.

When an interrupt arrives during stop, the block wakes in a fixed order. It returns the regulator to normal, turns the RC oscillator back on, and then restores flash power. A single down-counter times the whole wakeup. The core is released only when the counter reaches zero. The wakeup time is the oscillator startup term, plus one fixed term for each of the two stop options that was selected. Register and memory contents are never cleared by this block. The oscillators and the regulator are modelled as enables with counted delays.

Top module: `pwr_mode_seq`

## Requirements
- R1: After a synchronous reset, the block is in RUN (state code 0). The core and domain clock enables are 1, the RC oscillator enable is 1, and the PLL, crystal, regulator low-power and flash power-down outputs are 0.
- R2: In RUN, an entry request with deep-select 0 moves the state to SLEEP (code 1) on the next cycle. In SLEEP, only the core clock enable is 0. The domain clock and oscillator enables stay as they were in RUN.
- R3: In SLEEP, an interrupt returns the state to RUN (code 0) on the next cycle, and the core clock enable is 1 again.
- R4: An exception return counts as an entry request only when the return-to-sleep bit is 1. When that bit is 0, the state stays RUN.
- R5: In RUN, an entry request with deep-select 1 moves the state to STOP (code 2). In STOP, the core clock, domain clock, PLL, RC oscillator and crystal enables are all 0.
- R6: In STOP, the regulator low-power output equals the regulator bit captured at entry, and the flash power-down output equals the flash bit captured at entry. All four combinations are supported.
- R7: Changes to the regulator and flash bits while the block is stopped do not change the stop outputs and do not change the wakeup time.
- R8: An interrupt in STOP moves the state to WAKING (code 3). The core clock enable rises exactly N cycles after the edge that sampled the interrupt, where N = RC_CYC + (flash bit ? FLASH_CYC : 0) + (regulator bit ? REG_CYC : 0).
- R9: On entry to WAKING, the regulator low-power output falls. The RC oscillator enable rises after the regulator term has elapsed. The flash power-down output falls RC_CYC cycles after that.
- R10: Entry requests are ignored in STOP and WAKING, and interrupts are ignored in WAKING.
- R11: The state output uses the codes RUN=0, SLEEP=1, STOP=2 and WAKING=3.
- R12: The PLL and crystal enables follow their request inputs in RUN and SLEEP. They are 0 in STOP and WAKING, and they return only in RUN.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wfi_i | input | 1 | Wait-for-interrupt strobe |
| exc_ret_i | input | 1 | Exception-return strobe |
| ret_sleep_i | input | 1 | Return-to-sleep control bit |
| deep_i | input | 1 | Deep-select: 1 selects stop, 0 selects sleep |
| reg_lp_i | input | 1 | Stop with low-power regulator |
| flash_pd_i | input | 1 | Stop with flash powered down |
| irq_i | input | 1 | Any enabled interrupt or wakeup event |
| pll_req_i | input | 1 | PLL wanted while running |
| xtal_req_i | input | 1 | Crystal oscillator wanted while running |
| core_run_o | output | 1 | Core clock enable and core release |
| dom_clk_en_o | output | 1 | Core-domain clock enable |
| pll_en_o | output | 1 | PLL enable |
| rc_osc_en_o | output | 1 | Internal RC oscillator enable |
| xtal_en_o | output | 1 | External oscillator enable |
| reg_lp_o | output | 1 | Regulator low-power select |
| flash_pd_o | output | 1 | Flash power-down |
| state_o | output | 2 | Mode code |

## Verification
The hardest conditions to reach are the ones where inputs change while the block is stopped or waking. These include the configuration bits flipping mid-stop, and a wait strobe or a second interrupt arriving during the counted wakeup. Each of these could corrupt the latency or the restore order. The stimulus covers all four stop sub-modes. In each one, it inverts both configuration bits after entry, pulses the wait strobe while stopped, and fires an extra interrupt two cycles into WAKING. It then times the core release against the sum computed in the bench.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_STOP  = 2'd2,
    ST_WAKE  = 2'd3
  } pwr_state_e;

  typedef struct packed {
    logic lp;
    logic fpd;
  } stop_cfg_t;

endpackage

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wfi_i,
  input  logic       exc_ret_i,
  input  logic       ret_sleep_i,
  input  logic       deep_i,
  input  logic       reg_lp_i,
  input  logic       flash_pd_i,
  input  logic       irq_i,
  input  logic       wake_done_i,
  output pwr_state_e state_d,
  output stop_cfg_t  cfg_d,
  output logic       load_o,
  output logic       waking_o
);

  pwr_state_e state_q;
  stop_cfg_t  cfg_q;
  logic       entry_req;

  // An exception return only counts when return-to-sleep is armed
  assign entry_req = wfi_i | (exc_ret_i & ret_sleep_i);
  assign load_o    = (state_q == ST_STOP) && irq_i;
  assign waking_o  = (state_q == ST_WAKE);

  always_comb begin
    state_d = state_q;
    cfg_d   = cfg_q;
    case (state_q)
      ST_RUN: begin
        if (entry_req) begin
          if (deep_i) begin
            state_d   = ST_STOP;
            cfg_d.lp  = reg_lp_i;
            cfg_d.fpd = flash_pd_i;
          end else begin
            state_d = ST_SLEEP;
          end
        end
      end
      ST_SLEEP: if (irq_i) state_d = ST_RUN;
      ST_STOP:  if (irq_i) state_d = ST_WAKE;
      ST_WAKE:  if (wake_done_i) state_d = ST_RUN;
      default:  state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_RUN;
      cfg_q   <= '0;
    end else begin
      state_q <= state_d;
      cfg_q   <= cfg_d;
    end
  end

endmodule

// File: rtl/pwr_wake_timer.sv
module pwr_wake_timer
  import pwr_seq_pkg::*;
#(
  parameter int RC_CYC    = 16,
  parameter int FLASH_CYC = 24,
  parameter int REG_CYC   = 32,
  parameter int CW        = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic          active_i,
  input  stop_cfg_t     cfg_i,
  output logic [CW-1:0] cnt_d,
  output logic          done_o
);

  localparam logic [CW-1:0] RC_W  = CW'(RC_CYC);
  localparam logic [CW-1:0] FL_W  = CW'(FLASH_CYC);
  localparam logic [CW-1:0] RG_W  = CW'(REG_CYC);
  localparam logic [CW-1:0] ONE_W = CW'(1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] sum_w;

  assign sum_w  = RC_W + (cfg_i.fpd ? FL_W : '0) + (cfg_i.lp ? RG_W : '0);
  assign done_o = active_i && (cnt_q == ONE_W);

  always_comb begin
    if (load_i)                     cnt_d = sum_w;
    else if (active_i && !done_o)   cnt_d = cnt_q - ONE_W;
    else                            cnt_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

endmodule

// File: rtl/pwr_out_stage.sv
module pwr_out_stage
  import pwr_seq_pkg::*;
#(
  parameter int RC_CYC    = 16,
  parameter int FLASH_CYC = 24,
  parameter int CW        = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  pwr_state_e    state_d,
  input  stop_cfg_t     cfg_d,
  input  logic [CW-1:0] cnt_d,
  input  logic          pll_req_i,
  input  logic          xtal_req_i,
  output logic          core_run_o,
  output logic          dom_clk_en_o,
  output logic          pll_en_o,
  output logic          rc_osc_en_o,
  output logic          xtal_en_o,
  output logic          reg_lp_o,
  output logic          flash_pd_o,
  output logic [1:0]    state_o
);

  localparam logic [CW-1:0] RC_W = CW'(RC_CYC);
  localparam logic [CW-1:0] FL_W = CW'(FLASH_CYC);

  logic [CW-1:0] fl_term;
  logic          awake;
  logic          rc_d, fpd_d, lp_d;

  assign fl_term = cfg_d.fpd ? FL_W : '0;
  assign awake   = (state_d == ST_RUN) || (state_d == ST_SLEEP);

  always_comb begin
    rc_d  = 1'b1;
    fpd_d = 1'b0;
    lp_d  = 1'b0;
    case (state_d)
      ST_STOP: begin
        rc_d  = 1'b0;
        fpd_d = cfg_d.fpd;
        lp_d  = cfg_d.lp;
      end
      ST_WAKE: begin
        // regulator first, then RC oscillator, then flash power
        rc_d  = (cnt_d <= RC_W + fl_term);
        fpd_d = cfg_d.fpd && (cnt_d > fl_term);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      core_run_o   <= 1'b1;
      dom_clk_en_o <= 1'b1;
      pll_en_o     <= 1'b0;
      rc_osc_en_o  <= 1'b1;
      xtal_en_o    <= 1'b0;
      reg_lp_o     <= 1'b0;
      flash_pd_o   <= 1'b0;
      state_o      <= ST_RUN;
    end else begin
      core_run_o   <= (state_d == ST_RUN);
      dom_clk_en_o <= awake;
      pll_en_o     <= awake && pll_req_i;
      xtal_en_o    <= awake && xtal_req_i;
      rc_osc_en_o  <= rc_d;
      reg_lp_o     <= lp_d;
      flash_pd_o   <= fpd_d;
      state_o      <= state_d;
    end
  end

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_seq_pkg::*;
#(
  parameter int RC_CYC    = 16,
  parameter int FLASH_CYC = 24,
  parameter int REG_CYC   = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wfi_i,
  input  logic       exc_ret_i,
  input  logic       ret_sleep_i,
  input  logic       deep_i,
  input  logic       reg_lp_i,
  input  logic       flash_pd_i,
  input  logic       irq_i,
  input  logic       pll_req_i,
  input  logic       xtal_req_i,
  output logic       core_run_o,
  output logic       dom_clk_en_o,
  output logic       pll_en_o,
  output logic       rc_osc_en_o,
  output logic       xtal_en_o,
  output logic       reg_lp_o,
  output logic       flash_pd_o,
  output logic [1:0] state_o
);

  localparam int SUM_MAX = RC_CYC + FLASH_CYC + REG_CYC;
  localparam int CW      = $clog2(SUM_MAX + 1);

  pwr_state_e    state_d;
  stop_cfg_t     cfg_d;
  logic          load, waking, done;
  logic [CW-1:0] cnt_d;

  pwr_mode_fsm fsm_i (
    .clk        (clk),
    .rst        (rst),
    .wfi_i      (wfi_i),
    .exc_ret_i  (exc_ret_i),
    .ret_sleep_i(ret_sleep_i),
    .deep_i     (deep_i),
    .reg_lp_i   (reg_lp_i),
    .flash_pd_i (flash_pd_i),
    .irq_i      (irq_i),
    .wake_done_i(done),
    .state_d    (state_d),
    .cfg_d      (cfg_d),
    .load_o     (load),
    .waking_o   (waking)
  );

  pwr_wake_timer #(
    .RC_CYC   (RC_CYC),
    .FLASH_CYC(FLASH_CYC),
    .REG_CYC  (REG_CYC),
    .CW       (CW)
  ) tmr_i (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load),
    .active_i(waking),
    .cfg_i   (cfg_d),
    .cnt_d   (cnt_d),
    .done_o  (done)
  );

  pwr_out_stage #(
    .RC_CYC   (RC_CYC),
    .FLASH_CYC(FLASH_CYC),
    .CW       (CW)
  ) out_i (
    .clk         (clk),
    .rst         (rst),
    .state_d     (state_d),
    .cfg_d       (cfg_d),
    .cnt_d       (cnt_d),
    .pll_req_i   (pll_req_i),
    .xtal_req_i  (xtal_req_i),
    .core_run_o  (core_run_o),
    .dom_clk_en_o(dom_clk_en_o),
    .pll_en_o    (pll_en_o),
    .rc_osc_en_o (rc_osc_en_o),
    .xtal_en_o   (xtal_en_o),
    .reg_lp_o    (reg_lp_o),
    .flash_pd_o  (flash_pd_o),
    .state_o     (state_o)
  );

endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk
  import pwr_seq_pkg::*;
#(
  parameter int RC_CYC    = 16,
  parameter int FLASH_CYC = 24,
  parameter int REG_CYC   = 32
) (
  input logic       clk,
  input logic       rst,
  input logic       wfi_i,
  input logic       irq_i,
  input logic       core_run_o,
  input logic       dom_clk_en_o,
  input logic       pll_en_o,
  input logic       rc_osc_en_o,
  input logic       xtal_en_o,
  input logic       reg_lp_o,
  input logic       flash_pd_o,
  input logic [1:0] state_o
);

  logic [31:0] wake_n;
  logic [31:0] want_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      wake_n <= '0;
      want_n <= '0;
    end else begin
      wake_n <= (state_o == ST_WAKE) ? wake_n + 32'd1 : 32'd0;
      if (state_o == ST_STOP)
        want_n <= 32'(RC_CYC) + (flash_pd_o ? 32'(FLASH_CYC) : 32'd0)
                              + (reg_lp_o ? 32'(REG_CYC) : 32'd0);
    end
  end

  p_sleep_core_only_r2: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_SLEEP) |-> (!core_run_o && dom_clk_en_o && rc_osc_en_o));

  p_sleep_exit_r3: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_SLEEP && irq_i) |=> (state_o == ST_RUN && core_run_o));

  p_stop_all_off_r5: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_STOP) |-> (!core_run_o && !dom_clk_en_o && !pll_en_o
                              && !rc_osc_en_o && !xtal_en_o));

  p_cfg_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_STOP && $past(state_o) == ST_STOP)
      |-> ($stable(reg_lp_o) && $stable(flash_pd_o)));

  p_latency_sum_r8: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_RUN && $past(state_o) == ST_WAKE) |-> (wake_n == want_n));

  p_reg_before_rc_r9: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_WAKE && rc_osc_en_o) |-> !reg_lp_o);

  p_flash_after_rc_r9: assert property (@(posedge clk) disable iff (rst)
    ($fell(flash_pd_o) && state_o == ST_WAKE) |-> rc_osc_en_o);

  p_stop_holds_r10: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_STOP && !irq_i) |=> (state_o == ST_STOP));

  p_no_pll_waking_r12: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_WAKE) |-> (!pll_en_o && !xtal_en_o && !core_run_o));

endmodule

bind pwr_mode_seq pwr_mode_seq_chk #(
  .RC_CYC   (RC_CYC),
  .FLASH_CYC(FLASH_CYC),
  .REG_CYC  (REG_CYC)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .wfi_i       (wfi_i),
  .irq_i       (irq_i),
  .core_run_o  (core_run_o),
  .dom_clk_en_o(dom_clk_en_o),
  .pll_en_o    (pll_en_o),
  .rc_osc_en_o (rc_osc_en_o),
  .xtal_en_o   (xtal_en_o),
  .reg_lp_o    (reg_lp_o),
  .flash_pd_o  (flash_pd_o),
  .state_o     (state_o)
);

// File: tb/pwr_mode_seq_tb_top.sv
module pwr_mode_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int RC  = 16;
  localparam int FL  = 24;
  localparam int RG  = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wfi_i = 0, exc_ret_i = 0, ret_sleep_i = 0, deep_i = 0;
  logic reg_lp_i = 0, flash_pd_i = 0, irq_i = 0, pll_req_i = 0, xtal_req_i = 0;
  logic core_run_o, dom_clk_en_o, pll_en_o, rc_osc_en_o, xtal_en_o;
  logic reg_lp_o, flash_pd_o;
  logic [1:0] state_o;

  int total = 0;
  int bad   = 0;

  // reference model state
  int m_st = 0, m_cnt = 0, m_lp = 0, m_fp = 0, m_pll = 0, m_xt = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pwr_mode_seq #(.RC_CYC(RC), .FLASH_CYC(FL), .REG_CYC(RG)) dut_i (
    .clk(clk), .rst(rst), .wfi_i(wfi_i), .exc_ret_i(exc_ret_i),
    .ret_sleep_i(ret_sleep_i), .deep_i(deep_i), .reg_lp_i(reg_lp_i),
    .flash_pd_i(flash_pd_i), .irq_i(irq_i), .pll_req_i(pll_req_i),
    .xtal_req_i(xtal_req_i), .core_run_o(core_run_o),
    .dom_clk_en_o(dom_clk_en_o), .pll_en_o(pll_en_o),
    .rc_osc_en_o(rc_osc_en_o), .xtal_en_o(xtal_en_o),
    .reg_lp_o(reg_lp_o), .flash_pd_o(flash_pd_o), .state_o(state_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model, one step per rising edge
  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_cnt = 0; m_lp = 0; m_fp = 0; m_pll = 0; m_xt = 0;
    end else begin
      case (m_st)
        0: if (wfi_i || (exc_ret_i && ret_sleep_i)) begin
             if (deep_i) begin m_st = 2; m_lp = reg_lp_i; m_fp = flash_pd_i; end
             else m_st = 1;
           end
        1: if (irq_i) m_st = 0;
        2: if (irq_i) begin
             m_cnt = RC + (m_fp ? FL : 0) + (m_lp ? RG : 0);
             m_st = 3;
           end
        default: if (m_cnt == 1) begin m_st = 0; m_cnt = 0; end
                 else m_cnt = m_cnt - 1;
      endcase
      m_pll = (m_st < 2) && pll_req_i;
      m_xt  = (m_st < 2) && xtal_req_i;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      int f_term;
      f_term = m_fp ? FL : 0;
      chk("R11 state code", state_o, m_st);
      chk("R2 core clock", core_run_o, m_st == 0);
      chk("R5 domain clock", dom_clk_en_o, m_st < 2);
      chk("R9 rc osc", rc_osc_en_o,
          (m_st == 3) ? (m_cnt <= RC + f_term) : (m_st < 2));
      chk("R6 regulator lp", reg_lp_o, (m_st == 2) ? m_lp : 0);
      chk("R6 flash pd", flash_pd_o,
          (m_st == 2) ? m_fp : ((m_st == 3) ? (m_fp && m_cnt > f_term) : 0));
      chk("R12 pll", pll_en_o, m_pll);
      chk("R12 xtal", xtal_en_o, m_xt);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stop_wake(input logic lp, input logic fp);
    int n;
    int want;
    want = RC + (fp ? FL : 0) + (lp ? RG : 0);
    deep_i = 1; reg_lp_i = lp; flash_pd_i = fp; wfi_i = 1;
    @(negedge clk);
    wfi_i = 0; deep_i = 0;
    chk("R5 enter stop", state_o, 2);
    chk("R6 captured lp", reg_lp_o, lp);
    chk("R6 captured fpd", flash_pd_o, fp);
    reg_lp_i = !lp; flash_pd_i = !fp;
    cyc(3);
    chk("R7 lp frozen", reg_lp_o, lp);
    chk("R7 fpd frozen", flash_pd_o, fp);
    wfi_i = 1;
    @(negedge clk);
    wfi_i = 0;
    chk("R10 wfi ignored in stop", state_o, 2);
    irq_i = 1;
    @(negedge clk);
    irq_i = 0;
    chk("R9 regulator normal on wake", reg_lp_o, 0);
    n = 0;
    while (!core_run_o && n < 1000) begin
      irq_i = (n == 2);
      @(negedge clk);
      n++;
    end
    irq_i = 0;
    chk("R8 wakeup latency", n, want);
    reg_lp_i = 0; flash_pd_i = 0;
    cyc(3);
  endtask

  initial begin
    cyc(3);
    rst = 0;
    @(negedge clk);
    chk("R1 reset state", state_o, 0);
    chk("R1 reset core", core_run_o, 1);
    chk("R1 reset rc", rc_osc_en_o, 1);
    chk("R1 reset pll", pll_en_o, 0);
    chk("R1 reset flash", flash_pd_o, 0);
    pll_req_i = 1; xtal_req_i = 1;
    cyc(2);
    // light sleep
    wfi_i = 1;
    @(negedge clk);
    wfi_i = 0;
    chk("R2 sleep state", state_o, 1);
    chk("R2 sleep domain on", dom_clk_en_o, 1);
    chk("R12 pll kept in sleep", pll_en_o, 1);
    pll_req_i = 0;
    cyc(3);
    pll_req_i = 1;
    irq_i = 1;
    @(negedge clk);
    irq_i = 0;
    chk("R3 sleep exit", state_o, 0);
    chk("R3 core back", core_run_o, 1);
    // return to sleep on exception return
    ret_sleep_i = 1; exc_ret_i = 1;
    @(negedge clk);
    exc_ret_i = 0;
    chk("R4 sleep on return", state_o, 1);
    irq_i = 1;
    @(negedge clk);
    irq_i = 0; ret_sleep_i = 0;
    cyc(1);
    exc_ret_i = 1;
    @(negedge clk);
    exc_ret_i = 0;
    chk("R4 return ignored when bit clear", state_o, 0);
    irq_i = 1; cyc(2); irq_i = 0;
    chk("R3 irq in run ignored", state_o, 0);
    // four stop sub-modes
    stop_wake(0, 0);
    stop_wake(0, 1);
    xtal_req_i = 0;
    stop_wake(1, 0);
    stop_wake(1, 1);
    chk("R12 pll back in run", pll_en_o, 1);
    // deep stop entered through return-to-sleep
    ret_sleep_i = 1; deep_i = 1; exc_ret_i = 1;
    @(negedge clk);
    exc_ret_i = 0; deep_i = 0; ret_sleep_i = 0;
    chk("R4 return into stop", state_o, 2);
    irq_i = 1; @(negedge clk); irq_i = 0;
    cyc(RC + 4);
    chk("R8 short wake done", state_o, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule